// File: doc/BRIEF.md
# Fault Escalation Frame Sequencer

This block sits between the exception source of a processor core and its stack write port. It takes an exception or interrupt request, which carries a vector and, if required, an error code. It keeps a running count of faults that arrive before a delivery has finished. While the count is above one, the request is turned into a double-fault delivery. When the count reaches its limit, the block resets the core and delivers nothing. On acceptance it signals the core to roll its instruction and stack pointers back to the values saved at the start of the instruction and to drop any prefix state.

The return frame is written one word per cycle through a valid/ready push port. The words written and their order depend on three things: whether the core is in protected mode, whether the handler runs at a higher privilege, and whether the interrupted code was in virtual-8086 mode. The gate descriptor, already fetched by the core, selects the word width and whether the interrupt-enable flag is cleared. A push the stack port refuses ends the sequence and leaves the fault count as it was, so a fault that occurs during delivery escalates. When the last word has been written, the block updates its interrupt-enable and trap flag outputs and clears the fault count.

Top module: `fault_frame_seq`

## Requirements
- R1: Every accepted request adds one to the fault count. If the new count exceeds one, the delivered vector is the double-fault vector (default 8), and in protected mode a zero error code is pushed whether or not the request carried one.
- R2: If the new count equals the reset limit (default 3), `cpu_reset` pulses for one cycle, the count returns to zero, and no push and no restore pulse occur.
- R3: `restore_ctx` pulses for exactly one cycle, in the cycle after a delivering request is accepted.
- R4: The count returns to zero only when the last push completes and `done` pulses. A push that handshakes with `push_fail` high pulses `fail`, ends the sequence and keeps the count.
- R5: In protected mode with `vm_mode` high, the first four pushes are GS, FS, DS, ES in that order. After the ES push, `seg_null_load` pulses once.
- R6: In protected mode with `priv_change` or `vm_mode` high, the old SS and then the old ESP are pushed next. Then come EFLAGS, CS and EIP, and last the error code when one applies.
- R7: In protected mode `push_wide` equals `gate_32`. In real mode it is 0. In 16-bit pushes the upper half of `push_data` is zero.
- R8: An error code is pushed only in protected mode.
- R9: On `done`, `if_out` becomes 0 for an interrupt gate (`gate_intr`=1) and bit 9 of the old EFLAGS for a trap gate, and `tf_out` becomes 0. A failed sequence leaves both unchanged.
- R10: In real mode the frame is exactly FLAGS, CS, IP at 16 bits with interrupt-gate flag handling, and `priv_change` and `vm_mode` have no effect.
- R11: A request is taken only while `req_ready` is high, which is when no sequence is running. At most one push is issued per cycle, and `push_data` and `push_wide` hold while `push_valid` is high and `push_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception or interrupt request |
| req_ready | output | 1 | High when idle and able to take a request |
| req_vector | input | 8 | Requested vector |
| req_has_err | input | 1 | Request carries an error code |
| req_err_code | input | 32 | Error code value |
| prot_mode | input | 1 | Protected mode active |
| vm_mode | input | 1 | Interrupted code ran in virtual-8086 mode |
| priv_change | input | 1 | Handler is more privileged than the current level |
| gate_32 | input | 1 | Gate is 32-bit |
| gate_intr | input | 1 | 1 = interrupt gate, 0 = trap gate |
| old_eflags | input | 32 | Flags to save |
| old_cs | input | 16 | Code selector to save |
| old_eip | input | 32 | Restored instruction pointer to save |
| old_ss | input | 16 | Stack selector to save |
| old_esp | input | 32 | Stack pointer to save |
| seg_gs | input | 16 | GS selector |
| seg_fs | input | 16 | FS selector |
| seg_ds | input | 16 | DS selector |
| seg_es | input | 16 | ES selector |
| push_valid | output | 1 | Push word offered |
| push_ready | input | 1 | Stack port takes the word |
| push_fail | input | 1 | Stack port reports the push as faulted (sampled with ready) |
| push_data | output | 32 | Word to push |
| push_wide | output | 1 | 1 = 32-bit push, 0 = 16-bit push |
| deliver_vector | output | 8 | Vector being delivered |
| restore_ctx | output | 1 | Pulse: restore saved IP/SP and clear prefixes |
| seg_null_load | output | 1 | Pulse: load GS, FS, DS, ES with null |
| if_out | output | 1 | Interrupt-enable flag after delivery |
| tf_out | output | 1 | Trap flag after delivery |
| cpu_reset | output | 1 | Pulse: reset the core |
| done | output | 1 | Pulse: delivery completed |
| fail | output | 1 | Pulse: delivery aborted |

## Verification
Completion and abort can fall on the same handshake. When the stack port faults the last word of a frame, the cycle that would have ended the delivery must instead count as a fault. The bench provokes this by choosing the faulting push index at random over the whole frame, including the final word, while it holds off ready at random. Its judgement is that `fail` pulses with no `done`, the flags stay as they were, and the next request arrives as a double fault or as a reset.

// File: rtl/fault_frame_seq.sv
module fault_frame_seq #(
  parameter int VEC_W       = 8,
  parameter int DATA_W      = 32,
  parameter int SEL_W       = 16,
  parameter int DF_VEC      = 8,
  parameter int RESET_COUNT = 3,
  parameter int IF_BIT      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic              req_has_err,
  input  logic [DATA_W-1:0] req_err_code,
  input  logic              prot_mode,
  input  logic              vm_mode,
  input  logic              priv_change,
  input  logic              gate_32,
  input  logic              gate_intr,
  input  logic [DATA_W-1:0] old_eflags,
  input  logic [SEL_W-1:0]  old_cs,
  input  logic [DATA_W-1:0] old_eip,
  input  logic [SEL_W-1:0]  old_ss,
  input  logic [DATA_W-1:0] old_esp,
  input  logic [SEL_W-1:0]  seg_gs,
  input  logic [SEL_W-1:0]  seg_fs,
  input  logic [SEL_W-1:0]  seg_ds,
  input  logic [SEL_W-1:0]  seg_es,
  output logic              push_valid,
  input  logic              push_ready,
  input  logic              push_fail,
  output logic [DATA_W-1:0] push_data,
  output logic              push_wide,
  output logic [VEC_W-1:0]  deliver_vector,
  output logic              restore_ctx,
  output logic              seg_null_load,
  output logic              if_out,
  output logic              tf_out,
  output logic              cpu_reset,
  output logic              done,
  output logic              fail
);

  localparam int NSLOT  = 10;
  localparam int IDX_W  = $clog2(NSLOT);
  localparam int CNT_W  = $clog2(RESET_COUNT + 1);
  localparam int HALF_W = DATA_W / 2;
  localparam int LAST_SEG_SLOT = 3;

  logic                          busy_q;
  logic [CNT_W-1:0]              fault_cnt_q;
  logic [NSLOT-1:0]              pend_q;
  logic [NSLOT-1:0][DATA_W-1:0]  frame_q;
  logic [NSLOT-1:0][DATA_W-1:0]  frame_in;
  logic [NSLOT-1:0]              mask_in;
  logic                          wide_q, intr_q, oldif_q;
  logic [VEC_W-1:0]              vec_q;
  logic [IDX_W-1:0]              cur_idx;
  logic [NSLOT-1:0]              cur_bit;

  logic [CNT_W-1:0] cnt_inc;
  logic             escalate, trip, accept, hs, last_push;
  logic             pm_vm, pm_stack, pm_err;
  logic [DATA_W-1:0] err_val;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign cnt_inc   = fault_cnt_q + CNT_W'(1);
  assign escalate  = cnt_inc > CNT_W'(1);
  assign trip      = cnt_inc == CNT_W'(RESET_COUNT);

  assign pm_vm    = prot_mode && vm_mode;
  assign pm_stack = prot_mode && (priv_change || vm_mode);
  assign pm_err   = prot_mode && (escalate || req_has_err);
  assign err_val  = escalate ? '0 : req_err_code;

  function automatic logic [DATA_W-1:0] zx(input logic [SEL_W-1:0] s);
    return {{(DATA_W-SEL_W){1'b0}}, s};
  endfunction

  always_comb begin
    frame_in[0] = zx(seg_gs);
    frame_in[1] = zx(seg_fs);
    frame_in[2] = zx(seg_ds);
    frame_in[3] = zx(seg_es);
    frame_in[4] = zx(old_ss);
    frame_in[5] = old_esp;
    frame_in[6] = old_eflags;
    frame_in[7] = zx(old_cs);
    frame_in[8] = old_eip;
    frame_in[9] = err_val;
    mask_in = {pm_err, 3'b111, {2{pm_stack}}, {4{pm_vm}}};
  end

  always_comb begin
    cur_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (pend_q[i]) cur_idx = IDX_W'(i);
  end

  assign cur_bit    = NSLOT'(1) << cur_idx;
  assign last_push  = (pend_q & ~cur_bit) == '0;
  assign push_valid = busy_q;
  assign push_wide  = wide_q;
  assign push_data  = wide_q ? frame_q[cur_idx]
                             : {{(DATA_W-HALF_W){1'b0}}, frame_q[cur_idx][HALF_W-1:0]};
  assign hs         = push_valid && push_ready;
  assign deliver_vector = vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q        <= 1'b0;
      fault_cnt_q   <= '0;
      pend_q        <= '0;
      frame_q       <= '0;
      wide_q        <= 1'b0;
      intr_q        <= 1'b0;
      oldif_q       <= 1'b0;
      vec_q         <= '0;
      restore_ctx   <= 1'b0;
      seg_null_load <= 1'b0;
      cpu_reset     <= 1'b0;
      done          <= 1'b0;
      fail          <= 1'b0;
      if_out        <= 1'b0;
      tf_out        <= 1'b0;
    end else begin
      restore_ctx   <= 1'b0;
      seg_null_load <= 1'b0;
      cpu_reset     <= 1'b0;
      done          <= 1'b0;
      fail          <= 1'b0;
      if (accept) begin
        if (trip) begin
          fault_cnt_q <= '0;
          cpu_reset   <= 1'b1;
        end else begin
          fault_cnt_q <= cnt_inc;
          busy_q      <= 1'b1;
          restore_ctx <= 1'b1;
          vec_q       <= escalate ? VEC_W'(DF_VEC) : req_vector;
          pend_q      <= mask_in;
          frame_q     <= frame_in;
          wide_q      <= prot_mode && gate_32;
          intr_q      <= !prot_mode || gate_intr;
          oldif_q     <= old_eflags[IF_BIT];
        end
      end else if (hs) begin
        if (push_fail) begin
          busy_q <= 1'b0;
          pend_q <= '0;
          fail   <= 1'b1;
        end else begin
          pend_q <= pend_q & ~cur_bit;
          if (cur_idx == IDX_W'(LAST_SEG_SLOT)) seg_null_load <= 1'b1;
          if (last_push) begin
            busy_q      <= 1'b0;
            done        <= 1'b1;
            fault_cnt_q <= '0;
            if_out      <= intr_q ? 1'b0 : oldif_q;
            tf_out      <= 1'b0;
          end
        end
      end
    end
  end

  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> push_valid && $stable(push_data) && $stable(push_wide)); // R11
  AST_IDLE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !push_valid); // R11
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |-> !push_valid && !restore_ctx); // R2
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fault_cnt_q == '0); // R4
  AST_DONE_TF: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tf_out); // R9
  AST_DF_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && fault_cnt_q > CNT_W'(1) |-> deliver_vector == VEC_W'(DF_VEC)); // R1
  AST_NULL_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    seg_null_load |-> $past(push_valid && push_ready && !push_fail)); // R5

endmodule

// File: tb/fault_frame_seq_tb.sv
`timescale 1ns/100ps
module fault_frame_seq_tb;

  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_has_err = 0, prot_mode = 0, vm_mode = 0;
  logic        priv_change = 0, gate_32 = 0, gate_intr = 0;
  logic [7:0]  req_vector = 0;
  logic [31:0] req_err_code = 0, old_eflags = 0, old_eip = 0, old_esp = 0;
  logic [15:0] old_cs = 0, old_ss = 0, seg_gs = 0, seg_fs = 0, seg_ds = 0, seg_es = 0;
  logic        push_ready = 0, push_fail = 0;
  logic        req_ready, push_valid, push_wide, restore_ctx, seg_null_load;
  logic        if_out, tf_out, cpu_reset, done, fail;
  logic [31:0] push_data;
  logic [7:0]  deliver_vector;

  fault_frame_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vector(req_vector), .req_has_err(req_has_err), .req_err_code(req_err_code),
    .prot_mode(prot_mode), .vm_mode(vm_mode), .priv_change(priv_change),
    .gate_32(gate_32), .gate_intr(gate_intr), .old_eflags(old_eflags),
    .old_cs(old_cs), .old_eip(old_eip), .old_ss(old_ss), .old_esp(old_esp),
    .seg_gs(seg_gs), .seg_fs(seg_fs), .seg_ds(seg_ds), .seg_es(seg_es),
    .push_valid(push_valid), .push_ready(push_ready), .push_fail(push_fail),
    .push_data(push_data), .push_wide(push_wide), .deliver_vector(deliver_vector),
    .restore_ctx(restore_ctx), .seg_null_load(seg_null_load), .if_out(if_out),
    .tf_out(tf_out), .cpu_reset(cpu_reset), .done(done), .fail(fail)
  );

  int checks = 0, errors = 0, m_cnt = 0, cycles = 0;
  bit m_if = 0;
  logic [31:0] ed [10];
  bit          ew [10];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] tr(input logic [31:0] v, input bit w);
    return w ? v : {16'h0, v[15:0]};
  endfunction

  task automatic run_req(input int fail_at, input string tag);
    int  cnew, n, idx, nulls, guard, exp_nulls;
    bit  esc, trip, vm, stk, w, he, intr, got_done, got_fail, rdy;
    logic [7:0] vec;
    cnew = m_cnt + 1; esc = cnew > 1; trip = cnew == 3;
    vm = prot_mode & vm_mode; stk = prot_mode & (priv_change | vm_mode);
    w = prot_mode & gate_32; he = prot_mode & (esc | req_has_err);
    intr = !prot_mode | gate_intr; vec = esc ? 8'd8 : req_vector;
    n = 0;
    if (vm) begin
      ed[0] = {16'h0, seg_gs}; ed[1] = {16'h0, seg_fs};
      ed[2] = {16'h0, seg_ds}; ed[3] = {16'h0, seg_es}; n = 4;
    end
    if (stk) begin ed[n] = {16'h0, old_ss}; ed[n+1] = old_esp; n += 2; end
    ed[n] = old_eflags; ed[n+1] = {16'h0, old_cs}; ed[n+2] = old_eip; n += 3;
    if (he) begin ed[n] = esc ? 32'h0 : req_err_code; n++; end
    for (int i = 0; i < n; i++) begin ed[i] = tr(ed[i], w); ew[i] = w; end

    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready while idle", req_ready, 1);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (trip) begin
      chk(cpu_reset == 1'b1, "R2", "reset pulse", cpu_reset, 1);
      chk(push_valid == 1'b0, "R2", "no push on reset", push_valid, 0);
      chk(restore_ctx == 1'b0, "R2", "no restore on reset", restore_ctx, 0);
      m_cnt = 0;
      @(negedge clk);
      chk(cpu_reset == 1'b0, "R2", "reset is one cycle", cpu_reset, 0);
      chk(push_valid == 1'b0, "R2", "still no push", push_valid, 0);
      return;
    end
    chk(restore_ctx == 1'b1, "R3", "restore pulse", restore_ctx, 1);
    chk(deliver_vector == vec, "R1", "delivered vector", deliver_vector, vec);
    chk(req_ready == 1'b0, "R11", "busy blocks requests", req_ready, 0);
    idx = 0; nulls = 0; got_done = 0; got_fail = 0; guard = 0;
    forever begin
      if (seg_null_load) nulls++;
      if (guard == 1) chk(restore_ctx == 1'b0, "R3", "restore one cycle", restore_ctx, 0);
      if (done) got_done = 1;
      if (fail) got_fail = 1;
      if (got_done || got_fail || guard > 200) break;
      if (push_valid) begin
        rdy = ($urandom % 4) != 0;
        push_ready = rdy;
        push_fail = rdy && (idx == fail_at);
        if (rdy) begin
          if (idx < n) begin
            chk(push_data == ed[idx], "R6", "push word", push_data, ed[idx]);
            chk(push_wide == ew[idx], "R7", "push width", push_wide, ew[idx]);
          end
          idx++;
        end
      end else begin
        push_ready = 0; push_fail = 0;
      end
      guard++;
      @(negedge clk);
    end
    push_ready = 0; push_fail = 0;
    exp_nulls = (vm && (fail_at >= n || fail_at > 3)) ? 1 : 0;
    chk(nulls == exp_nulls, "R5", "null load pulses", nulls, exp_nulls);
    if (fail_at < n) begin
      chk(got_fail && !got_done, "R4", "abort on failed push", got_fail, 1);
      m_cnt = cnew;
    end else begin
      chk(got_done && !got_fail, "R4", "completion", got_done, 1);
      chk(idx == n, tag, "push count", idx, n);
      m_cnt = 0;
      m_if = intr ? 1'b0 : old_eflags[9];
    end
    chk(if_out == m_if, "R9", "IF after sequence", if_out, m_if);
    chk(tf_out == 1'b0, "R9", "TF after sequence", tf_out, 0);
  endtask

  task automatic set_ctx(input bit p, input bit v, input bit pc, input bit g32,
                         input bit gi, input bit he, input logic [7:0] vecv);
    prot_mode = p; vm_mode = v; priv_change = pc; gate_32 = g32; gate_intr = gi;
    req_has_err = he; req_vector = vecv;
    req_err_code = $urandom; old_eflags = $urandom; old_eip = $urandom;
    old_esp = $urandom; old_cs = 16'($urandom); old_ss = 16'($urandom);
    seg_gs = 16'($urandom); seg_fs = 16'($urandom);
    seg_ds = 16'($urandom); seg_es = 16'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && push_valid == 1'b0, "R11", "reset idle", push_valid, 0);
    chk(cpu_reset == 1'b0 && done == 1'b0 && fail == 1'b0, "R2", "reset pulses low", cpu_reset, 0);
    chk(if_out == 1'b0 && tf_out == 1'b0, "R9", "reset flags", if_out, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    set_ctx(1, 0, 0, 1, 1, 1, 8'd14); run_req(99, "R8");
    set_ctx(1, 1, 0, 0, 0, 0, 8'd13); old_eflags[9] = 1; run_req(99, "R5");
    set_ctx(1, 0, 1, 1, 0, 0, 8'd32); old_eflags[9] = 0; run_req(99, "R6");
    set_ctx(0, 1, 1, 1, 0, 1, 8'd3);  run_req(99, "R10");
    set_ctx(1, 0, 0, 1, 1, 0, 8'd6);  run_req(1, "R4");
    set_ctx(1, 0, 0, 1, 1, 0, 8'd14); run_req(99, "R1");
    set_ctx(1, 1, 1, 1, 0, 1, 8'd20); run_req(8, "R4");
    set_ctx(1, 0, 0, 0, 1, 0, 8'd21); run_req(3, "R1");
    set_ctx(1, 0, 0, 1, 1, 1, 8'd22); run_req(0, "R2");
    set_ctx(1, 0, 1, 1, 1, 0, 8'd23); run_req(99, "R1");

    for (int t = 0; t < 80; t++) begin
      set_ctx($urandom % 4 != 0, $urandom % 2, $urandom % 2, $urandom % 2,
              $urandom % 2, $urandom % 2, 8'($urandom));
      run_req(($urandom % 5 == 0) ? int'($urandom % 10) : 99, "R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule